// File: doc/BRIEF.md
# Trapezoidal Step Pulse Generator

This block drives a stepper or servo amplifier with a train of motion pulses. A move begins at a starting frequency. The frequency then rises by a fixed acceleration step once per control period until it reaches a target frequency, and it stays there. Near the end of the move the frequency falls by a deceleration step each period, so the last pulse comes out at low speed. Each move takes a 32-bit pulse count, delivered as two 16-bit words, together with a mode flag. In relative mode the count is the move length. In absolute mode the count is a signed destination, and the move length is the distance from the current position.

A phase accumulator clocked by the system clock produces the pulses. The block keeps a position register that is loaded from the position input when a move is accepted. It steps by one, up or down, on every pulse. A busy flag covers the whole move. The block decides when to slow down by counting the pulses emitted while it was speeding up. It enters deceleration once the remaining count no longer exceeds that figure. A short move therefore gives a triangular profile instead of a trapezoid.

Top module: `step_pulse_gen`

## Requirements
- R1: In relative mode (mode flag 0), an accepted move with a nonzero count produces exactly that many rising edges on the pulse output. The position output ends at the sampled position input plus the count.
- R2: In absolute mode (mode flag 1), the count is a signed 32-bit destination. The move length is its absolute difference from the sampled position input. The position output steps toward the destination on each pulse and ends equal to it.
- R3: Each 32-bit quantity (count, starting frequency, target frequency) is formed as {upper word, lower word} from its two 16-bit inputs. The upper word is significant.
- R4: A move begins at the starting frequency. While accelerating, the frequency rises by the acceleration rate at the end of every control period and never decreases. A step that would reach or pass the target is clamped to the target, and acceleration ends there.
- R5: The target frequency is forced into the range 1 to F_MAX. A starting frequency above the effective target is reduced to it, and a starting frequency of 0 behaves as 1. The frequency never exceeds the effective target.
- R6: While decelerating, the frequency falls by the deceleration rate at the end of every control period. It never increases and never drops below the effective starting frequency.
- R7: Deceleration begins in the first cycle in which the remaining pulse count is no greater than the number of pulses emitted during acceleration. This holds while accelerating (triangular profile) and while cruising. Once decelerating, the move never accelerates again.
- R8: Each clock, the phase advances by the current frequency modulo PHASE_MOD. Every wrap is one pulse. The pulse output is high while the phase is below PHASE_MOD/2. The phase starts a move at PHASE_MOD/2, so the output is low when busy rises, and it is low whenever busy is low.
- R9: Busy rises the cycle after an accepted start. It falls once the high half of the last pulse has ended. A start while busy is ignored. A start whose move length is 0 loads the position but never raises busy.
- R10: A ramp rate of 0 is used as 1. With the LEGACY_RAMP option set, rates above 2000 are used as 2000.
- R11: After reset, busy, the pulse output and the position output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a move (sampled when idle) |
| abs_mode_i | input | 1 | 0 relative count, 1 absolute destination |
| cnt_lo_i | input | 16 | Count / destination, lower word |
| cnt_hi_i | input | 16 | Count / destination, upper word |
| fstart_lo_i | input | 16 | Starting frequency, lower word |
| fstart_hi_i | input | 16 | Starting frequency, upper word |
| ftgt_lo_i | input | 16 | Target frequency, lower word |
| ftgt_hi_i | input | 16 | Target frequency, upper word |
| acc_rate_i | input | 16 | Frequency increase per control period |
| dec_rate_i | input | 16 | Frequency decrease per control period |
| pos_i | input | 32 | Current position, loaded on an accepted start |
| pulse_o | output | 1 | Motion pulse train |
| busy_o | output | 1 | Move in progress |
| pos_o | output | 32 | Updated position |

## Verification
The in-line assertions check on every cycle that the frequency stays between the effective start and target frequencies. They also check that it only rises during acceleration and only falls during deceleration, that deceleration never returns to acceleration, and that the position moves by at most one per cycle. Two further properties are checked each cycle: pulses stay quiet while idle, and the move reaches its tail with nothing left to emit. Only the bench scenarios can show the exact pulse counts and final positions in both modes and the word assembly. The same holds for the clamping of starting and target frequencies, the rate substitution with and without the legacy limit, the triangular switch point, and the rejection of starts while busy. The bench shows these by matching every cycle against an independent behavioural model.

// File: rtl/step_pkg.sv
package step_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_UP   = 3'd1,
      ST_HOLD = 3'd2,
      ST_DOWN = 3'd3,
      ST_TAIL = 3'd4
   } ramp_st_e;
endpackage

// File: rtl/step_move_calc.sv
module step_move_calc #(
   parameter int CW          = 32,
   parameter int FW          = 17,
   parameter int RW          = 16,
   parameter int F_MAX       = 100000,
   parameter bit LEGACY_RAMP = 1'b0,
   parameter int LEGACY_MAX  = 2000
) (
   input  logic          abs_mode,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] pos,
   input  logic [CW-1:0] fstart_raw,
   input  logic [CW-1:0] ftgt_raw,
   input  logic [RW-1:0] acc_raw,
   input  logic [RW-1:0] dec_raw,
   output logic [CW-1:0] len,
   output logic          neg,
   output logic [FW-1:0] tgt_eff,
   output logic [FW-1:0] floor_eff,
   output logic [RW-1:0] acc_eff,
   output logic [RW-1:0] dec_eff
);
   logic signed [CW:0] diff;
   logic [CW-1:0]      mag;
   logic [FW-1:0]      start_c;
   logic [RW-1:0]      rate_cap;

   assign diff = $signed({cnt[CW-1], cnt}) - $signed({pos[CW-1], pos});
   assign mag  = diff[CW] ? CW'(-diff) : CW'(diff);
   assign len  = abs_mode ? mag : cnt;
   assign neg  = abs_mode & diff[CW];

   always_comb begin
      if (ftgt_raw == '0)                 tgt_eff = FW'(1);
      else if (ftgt_raw > CW'(F_MAX))     tgt_eff = FW'(F_MAX);
      else                                tgt_eff = FW'(ftgt_raw);
      if (fstart_raw > CW'(tgt_eff))      start_c = tgt_eff;
      else                                start_c = FW'(fstart_raw);
      floor_eff = (start_c == '0) ? FW'(1) : start_c;
   end

   generate
      if (LEGACY_RAMP) begin : g_legacy
         assign rate_cap = RW'(LEGACY_MAX);
      end else begin : g_full
         assign rate_cap = '1;
      end
   endgenerate

   assign acc_eff = (acc_raw == '0) ? RW'(1) : ((acc_raw > rate_cap) ? rate_cap : acc_raw);
   assign dec_eff = (dec_raw == '0) ? RW'(1) : ((dec_raw > rate_cap) ? rate_cap : dec_raw);
endmodule

// File: rtl/step_phase_gen.sv
module step_phase_gen #(
   parameter int FW        = 17,
   parameter int PHASE_MOD = 1000000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          run,
   input  logic          tail,
   input  logic [FW-1:0] freq,
   output logic          wrap,
   output logic          tail_done,
   output logic          pulse
);
   localparam int PW   = $clog2(PHASE_MOD) + 1;
   localparam int HALF = PHASE_MOD / 2;

   logic [PW-1:0] ph_q;
   logic [PW-1:0] sum;

   assign sum       = ph_q + PW'(freq);
   assign wrap      = run && (sum >= PW'(PHASE_MOD));
   assign tail_done = tail && (sum >= PW'(HALF));
   assign pulse     = (run || tail) && (ph_q < PW'(HALF));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ph_q <= PW'(HALF);
      else if (load)  ph_q <= PW'(HALF);
      else if (wrap)  ph_q <= sum - PW'(PHASE_MOD);
      else if (run || tail) ph_q <= sum;
   end

   AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (ph_q < PW'(PHASE_MOD))) else $error("phase out of range"); // R8
endmodule

// File: rtl/step_ramp_ctrl.sv
module step_ramp_ctrl
   import step_pkg::*;
#(
   parameter int CW          = 32,
   parameter int FW          = 17,
   parameter int RW          = 16,
   parameter int CTRL_CYCLES = 4000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [CW-1:0] len_i,
   input  logic [FW-1:0] tgt_i,
   input  logic [FW-1:0] floor_i,
   input  logic [RW-1:0] acc_i,
   input  logic [RW-1:0] dec_i,
   input  logic          wrap_i,
   input  logic          tail_done_i,
   output ramp_st_e      state_o,
   output logic [FW-1:0] freq_o
);
   localparam int TW = $clog2(CTRL_CYCLES + 1);
   localparam int SW = ((FW > RW) ? FW : RW) + 1;

   ramp_st_e      state_q;
   logic [CW-1:0] rem_q, up_q;
   logic [FW-1:0] f_q, tgt_q, floor_q;
   logic [RW-1:0] ar_q, dr_q;
   logic [TW-1:0] tc_q;
   logic          tick, down_now, last;
   logic [SW-1:0] up_sum, dn_lim;

   assign tick     = (tc_q == TW'(CTRL_CYCLES - 1));
   assign down_now = (rem_q <= up_q);
   assign last     = wrap_i && (rem_q == CW'(1));
   assign up_sum   = SW'(f_q) + SW'(ar_q);
   assign dn_lim   = SW'(floor_q) + SW'(dr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rem_q   <= '0;
         up_q    <= '0;
         f_q     <= '0;
         tgt_q   <= '0;
         floor_q <= '0;
         ar_q    <= '0;
         dr_q    <= '0;
         tc_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (go) begin
                  state_q <= ST_UP;
                  f_q     <= floor_i;
                  rem_q   <= len_i;
                  up_q    <= '0;
                  tc_q    <= '0;
                  tgt_q   <= tgt_i;
                  floor_q <= floor_i;
                  ar_q    <= acc_i;
                  dr_q    <= dec_i;
               end
            end
            ST_UP, ST_HOLD, ST_DOWN: begin
               tc_q <= tick ? '0 : tc_q + TW'(1);
               if (wrap_i) begin
                  rem_q <= rem_q - CW'(1);
                  if (state_q == ST_UP) up_q <= up_q + CW'(1);
               end
               if (last) begin
                  state_q <= ST_TAIL;
               end else if (state_q != ST_DOWN && down_now) begin
                  state_q <= ST_DOWN;
               end else if (state_q == ST_UP && tick) begin
                  if (up_sum >= SW'(tgt_q)) begin
                     f_q     <= tgt_q;
                     state_q <= ST_HOLD;
                  end else begin
                     f_q <= FW'(up_sum);
                  end
               end else if (state_q == ST_DOWN && tick) begin
                  f_q <= (SW'(f_q) >= dn_lim) ? FW'(SW'(f_q) - SW'(dr_q)) : floor_q;
               end
            end
            ST_TAIL: begin
               if (tail_done_i) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = state_q;
   assign freq_o  = f_q;

   AST_FREQ_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> (f_q <= tgt_q)) else $error("above target"); // R5
   AST_FREQ_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> (f_q >= floor_q)) else $error("below floor"); // R6
   AST_UP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_UP) |=> (f_q >= $past(f_q))) else $error("fell while ramping up"); // R4
   AST_DOWN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DOWN) |=> (f_q <= $past(f_q))) else $error("rose while ramping down"); // R6
   AST_NO_REACCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DOWN) |=> (state_q == ST_DOWN || state_q == ST_TAIL)) else $error("left deceleration"); // R7
   AST_TAIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TAIL) |-> (rem_q == '0)) else $error("tail with pulses left"); // R9
endmodule

// File: rtl/step_pulse_gen.sv
module step_pulse_gen
   import step_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int RW          = 16,
   parameter int F_MAX       = 100000,
   parameter int PHASE_MOD   = 1000000,
   parameter int CTRL_CYCLES = 4000,
   parameter bit LEGACY_RAMP = 1'b0,
   parameter int LEGACY_MAX  = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abs_mode_i,
   input  logic [WORD_W-1:0] cnt_lo_i,
   input  logic [WORD_W-1:0] cnt_hi_i,
   input  logic [WORD_W-1:0] fstart_lo_i,
   input  logic [WORD_W-1:0] fstart_hi_i,
   input  logic [WORD_W-1:0] ftgt_lo_i,
   input  logic [WORD_W-1:0] ftgt_hi_i,
   input  logic [RW-1:0]     acc_rate_i,
   input  logic [RW-1:0]     dec_rate_i,
   input  logic [2*WORD_W-1:0] pos_i,
   output logic              pulse_o,
   output logic              busy_o,
   output logic [2*WORD_W-1:0] pos_o
);
   localparam int CW = 2 * WORD_W;
   localparam int FW = $clog2(F_MAX + 1);

   initial begin
      assert (PHASE_MOD >= 2 * F_MAX) else $error("PHASE_MOD must be at least twice F_MAX");
      assert (CTRL_CYCLES >= 1)       else $error("CTRL_CYCLES must be positive");
      assert (F_MAX >= 1)             else $error("F_MAX must be positive");
      assert (LEGACY_MAX >= 1 && LEGACY_MAX < (1 << RW)) else $error("LEGACY_MAX out of range");
   end

   logic [CW-1:0] len;
   logic          neg, neg_q;
   logic [FW-1:0] tgt_eff, floor_eff, freq;
   logic [RW-1:0] acc_eff, dec_eff;
   logic          idle, go, wrap, tail_done, run, tail;
   ramp_st_e      state;
   logic [CW-1:0] pos_q;

   step_move_calc #(
      .CW(CW), .FW(FW), .RW(RW), .F_MAX(F_MAX),
      .LEGACY_RAMP(LEGACY_RAMP), .LEGACY_MAX(LEGACY_MAX)
   ) u_calc (
      .abs_mode   (abs_mode_i),
      .cnt        ({cnt_hi_i, cnt_lo_i}),
      .pos        (pos_i),
      .fstart_raw ({fstart_hi_i, fstart_lo_i}),
      .ftgt_raw   ({ftgt_hi_i, ftgt_lo_i}),
      .acc_raw    (acc_rate_i),
      .dec_raw    (dec_rate_i),
      .len        (len),
      .neg        (neg),
      .tgt_eff    (tgt_eff),
      .floor_eff  (floor_eff),
      .acc_eff    (acc_eff),
      .dec_eff    (dec_eff)
   );

   assign idle = (state == ST_IDLE);
   assign go   = start_i && idle && (len != '0);
   assign run  = (state == ST_UP) || (state == ST_HOLD) || (state == ST_DOWN);
   assign tail = (state == ST_TAIL);

   step_ramp_ctrl #(
      .CW(CW), .FW(FW), .RW(RW), .CTRL_CYCLES(CTRL_CYCLES)
   ) u_ramp (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (go),
      .len_i       (len),
      .tgt_i       (tgt_eff),
      .floor_i     (floor_eff),
      .acc_i       (acc_eff),
      .dec_i       (dec_eff),
      .wrap_i      (wrap),
      .tail_done_i (tail_done),
      .state_o     (state),
      .freq_o      (freq)
   );

   step_phase_gen #(
      .FW(FW), .PHASE_MOD(PHASE_MOD)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (go),
      .run       (run),
      .tail      (tail),
      .freq      (freq),
      .wrap      (wrap),
      .tail_done (tail_done),
      .pulse     (pulse_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         neg_q <= 1'b0;
      end else if (start_i && idle) begin
         pos_q <= pos_i;
         neg_q <= neg;
      end else if (wrap) begin
         pos_q <= neg_q ? pos_q - CW'(1) : pos_q + CW'(1);
      end
   end

   assign pos_o  = pos_q;
   assign busy_o = !idle;

   AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (pos_o == $past(pos_o) || pos_o == $past(pos_o) + CW'(1) ||
                  pos_o == $past(pos_o) - CW'(1))) else $error("position jumped"); // R1
   AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !pulse_o) else $error("pulse while idle"); // R8
endmodule

// File: tb/sim_step_pulse_gen.sv
`timescale 1ns/1ps
module sim_step_pulse_gen;
   localparam int  FMAX  = 100000;
   localparam int  PMOD  = 1000000;
   localparam int  CTRL  = 200;
   localparam longint HALF = PMOD / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        start = 1'b0, am = 1'b0;
   logic [15:0] c_lo = '0, c_hi = '0, fs_lo = '0, fs_hi = '0, ft_lo = '0, ft_hi = '0, ar = '0, dr = '0;
   logic [31:0] pin = '0;
   logic        pulse0, busy0, pulse1, busy1;
   logic [31:0] pos0, pos1;

   step_pulse_gen #(.F_MAX(FMAX), .PHASE_MOD(PMOD), .CTRL_CYCLES(CTRL), .LEGACY_RAMP(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .abs_mode_i(am),
      .cnt_lo_i(c_lo), .cnt_hi_i(c_hi), .fstart_lo_i(fs_lo), .fstart_hi_i(fs_hi),
      .ftgt_lo_i(ft_lo), .ftgt_hi_i(ft_hi), .acc_rate_i(ar), .dec_rate_i(dr),
      .pos_i(pin), .pulse_o(pulse0), .busy_o(busy0), .pos_o(pos0));

   step_pulse_gen #(.F_MAX(FMAX), .PHASE_MOD(PMOD), .CTRL_CYCLES(CTRL), .LEGACY_RAMP(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .abs_mode_i(am),
      .cnt_lo_i(c_lo), .cnt_hi_i(c_hi), .fstart_lo_i(fs_lo), .fstart_hi_i(fs_hi),
      .ftgt_lo_i(ft_lo), .ftgt_hi_i(ft_hi), .acc_rate_i(ar), .dec_rate_i(dr),
      .pos_i(pin), .pulse_o(pulse1), .busy_o(busy1), .pos_o(pos1));

   int n_chk = 0, n_fail = 0, cyc = 0;
   string cur_tag = "R11";
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Behavioural reference: states 0 idle, 1 ramp up, 2 cruise, 3 ramp down, 4 tail
   int     m_st[2];
   longint m_f[2], m_rem[2], m_up[2], m_tc[2], m_ph[2], m_tgt[2], m_flr[2], m_ar[2], m_dr[2];
   logic [31:0] m_pos[2];
   bit     m_neg[2];

   always @(posedge clk) begin
      for (int k = 0; k < 2; k++) begin
         if (!rst_n) begin
            m_st[k] = 0; m_f[k] = 0; m_rem[k] = 0; m_up[k] = 0; m_tc[k] = 0;
            m_ph[k] = HALF; m_pos[k] = '0; m_neg[k] = 1'b0;
         end else if (m_st[k] == 0) begin
            if (start) begin
               longint ln, tg, sf, a, d, fsv, ftv;
               if (am) begin
                  longint df;
                  df = longint'($signed({c_hi, c_lo})) - longint'($signed(pin));
                  m_neg[k] = (df < 0);
                  ln = (df < 0) ? -df : df;
               end else begin
                  m_neg[k] = 1'b0;
                  ln = longint'({c_hi, c_lo});
               end
               fsv = longint'({fs_hi, fs_lo});
               ftv = longint'({ft_hi, ft_lo});
               tg = (ftv == 0) ? 1 : ((ftv > FMAX) ? FMAX : ftv);
               sf = (fsv > tg) ? tg : fsv;
               if (sf == 0) sf = 1;
               a = (ar == 0) ? 1 : longint'(ar);
               d = (dr == 0) ? 1 : longint'(dr);
               if (k == 1 && a > 2000) a = 2000;
               if (k == 1 && d > 2000) d = 2000;
               m_pos[k] = pin;
               if (ln != 0) begin
                  m_st[k] = 1; m_f[k] = sf; m_rem[k] = ln; m_up[k] = 0; m_tc[k] = 0;
                  m_ph[k] = HALF; m_tgt[k] = tg; m_flr[k] = sf; m_ar[k] = a; m_dr[k] = d;
               end
            end
         end else if (m_st[k] == 4) begin
            if (m_ph[k] + m_f[k] >= HALF) m_st[k] = 0;
            m_ph[k] = m_ph[k] + m_f[k];
         end else begin
            bit tk, wr;
            longint old_rem, old_up;
            tk = (m_tc[k] == CTRL - 1);
            m_tc[k] = tk ? 0 : m_tc[k] + 1;
            old_rem = m_rem[k];
            old_up = m_up[k];
            m_ph[k] = m_ph[k] + m_f[k];
            wr = (m_ph[k] >= PMOD);
            if (wr) begin
               m_ph[k] = m_ph[k] - PMOD;
               m_rem[k] = m_rem[k] - 1;
               m_pos[k] = m_neg[k] ? m_pos[k] - 32'd1 : m_pos[k] + 32'd1;
               if (m_st[k] == 1) m_up[k] = m_up[k] + 1;
            end
            if (wr && old_rem == 1) m_st[k] = 4;
            else if (m_st[k] != 3 && old_rem <= old_up) m_st[k] = 3;
            else if (m_st[k] == 1 && tk) begin
               if (m_f[k] + m_ar[k] >= m_tgt[k]) begin m_f[k] = m_tgt[k]; m_st[k] = 2; end
               else m_f[k] = m_f[k] + m_ar[k];
            end else if (m_st[k] == 3 && tk) begin
               m_f[k] = (m_f[k] - m_dr[k] >= m_flr[k]) ? m_f[k] - m_dr[k] : m_flr[k];
            end
         end
      end
   end

   // Per-cycle comparison against the model, plus rising-edge counting
   int  edges0 = 0, edges1 = 0;
   logic prev0 = 1'b0, prev1 = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit mb0, mb1, mp0, mp1;
         mb0 = (m_st[0] != 0); mb1 = (m_st[1] != 0);
         mp0 = mb0 && (m_ph[0] < HALF); mp1 = mb1 && (m_ph[1] < HALF);
         chk(busy0 == mb0, cur_tag, "u0 busy", longint'(busy0), longint'(mb0));
         chk(pulse0 == mp0, cur_tag, "u0 pulse", longint'(pulse0), longint'(mp0));
         chk(pos0 == m_pos[0], cur_tag, "u0 pos", longint'(pos0), longint'(m_pos[0]));
         chk(busy1 == mb1, cur_tag, "u1 busy", longint'(busy1), longint'(mb1));
         chk(pulse1 == mp1, cur_tag, "u1 pulse", longint'(pulse1), longint'(mp1));
         chk(pos1 == m_pos[1], cur_tag, "u1 pos", longint'(pos1), longint'(m_pos[1]));
         if (pulse0 && !prev0) edges0++;
         if (pulse1 && !prev1) edges1++;
         prev0 = pulse0; prev1 = pulse1;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000 && !done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 190000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic run_move(input bit m, input logic [31:0] cnt, input logic [31:0] p,
                           input logic [31:0] fsv, input logic [31:0] ftv,
                           input logic [15:0] a, input logic [15:0] d, input string tag,
                           input longint exp_len, input logic [31:0] exp_pos, input bit poke);
      @(negedge clk);
      cur_tag = tag;
      am = m; {c_hi, c_lo} = cnt; pin = p; {fs_hi, fs_lo} = fsv; {ft_hi, ft_lo} = ftv;
      ar = a; dr = d;
      edges0 = 0; edges1 = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 60000; i++) begin
         if (m_st[0] == 0 && m_st[1] == 0) break;
         if (poke && i == 150) begin
            {c_hi, c_lo} = 32'd5; pin = 32'd7777; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk(edges0 == exp_len, tag, "u0 pulse count", longint'(edges0), exp_len);
      chk(edges1 == exp_len, tag, "u1 pulse count", longint'(edges1), exp_len);
      chk(pos0 == exp_pos, tag, "u0 final position", longint'(pos0), longint'(exp_pos));
      chk(pos1 == exp_pos, tag, "u1 final position", longint'(pos1), longint'(exp_pos));
      chk(busy0 == 1'b0 && pulse0 == 1'b0, "R8", "idle pulse/busy low", longint'({busy0, pulse0}), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R11: reset state
      chk(busy0 == 1'b0, "R11", "reset busy", longint'(busy0), 0);
      chk(pulse0 == 1'b0, "R11", "reset pulse", longint'(pulse0), 0);
      chk(pos0 == 32'd0, "R11", "reset position", longint'(pos0), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 R4: relative trapezoid
      run_move(1'b0, 32'd200, 32'd0, 32'd20000, 32'd100000, 16'd20000, 16'd20000, "R1", 200, 32'd200, 1'b0);
      // R2: absolute move downward
      run_move(1'b1, 32'd900, 32'd1000, 32'd30000, 32'd80000, 16'd10000, 16'd10000, "R2", 100, 32'd900, 1'b0);
      // R2: absolute move crossing zero
      run_move(1'b1, 32'hFFFF_FFCE, 32'd50, 32'd30000, 32'd80000, 16'd10000, 16'd10000, "R2", 100, 32'hFFFF_FFCE, 1'b0);
      // R3: upper words significant
      run_move(1'b1, 32'h0001_0032, 32'h0001_0000, 32'd40000, 32'h0001_86A0, 16'd30000, 16'd30000, "R3", 50, 32'h0001_0032, 1'b0);
      // R7: triangular profile
      run_move(1'b0, 32'd30, 32'd10, 32'd10000, 32'd100000, 16'd5000, 16'd5000, "R7", 30, 32'd40, 1'b0);
      // R4: long cruise
      run_move(1'b0, 32'd300, 32'd0, 32'd50000, 32'd90000, 16'd8000, 16'd12000, "R4", 300, 32'd300, 1'b0);
      // R5: start above target, target above maximum
      run_move(1'b0, 32'd80, 32'd0, 32'd90000, 32'd50000, 16'd1000, 16'd1000, "R5", 80, 32'd80, 1'b0);
      run_move(1'b0, 32'd60, 32'd100, 32'd200000, 32'd250000, 16'd1000, 16'd1000, "R5", 60, 32'd160, 1'b0);
      // R6: deceleration toward the floor
      run_move(1'b0, 32'd120, 32'd0, 32'd25000, 32'd100000, 16'd40000, 16'd6000, "R6", 120, 32'd120, 1'b0);
      // R10: legacy cap differs between u0 and u1; zero rates
      run_move(1'b0, 32'd150, 32'd0, 32'd10000, 32'd60000, 16'd30000, 16'd30000, "R10", 150, 32'd150, 1'b0);
      run_move(1'b0, 32'd60, 32'd0, 32'd20000, 32'd100000, 16'd0, 16'd0, "R10", 60, 32'd60, 1'b0);
      // R9: zero-length moves and a start while busy
      run_move(1'b0, 32'd0, 32'd444, 32'd20000, 32'd100000, 16'd1000, 16'd1000, "R9", 0, 32'd444, 1'b0);
      run_move(1'b1, 32'd555, 32'd555, 32'd20000, 32'd100000, 16'd1000, 16'd1000, "R9", 0, 32'd555, 1'b0);
      run_move(1'b0, 32'd120, 32'd0, 32'd30000, 32'd90000, 16'd10000, 16'd10000, "R9", 120, 32'd120, 1'b1);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule